// File: doc/BRIEF.md
# Two-Pass 8x8 Inverse Transform

This block performs a separable two-dimensional inverse transform on an 8x8 block of signed 16-bit coefficients. Coefficient rows enter one per accepted cycle over a valid/ready port. As each row arrives, an eight-point butterfly applies the first one-dimensional pass to it. The result is written into one bank of a ping-pong transpose buffer. When a bank is complete, a second butterfly reads it one column at a time and applies the second pass. The eight result columns are collected in an output buffer. That buffer is then drained as eight 16-bit residual rows over a second valid/ready port, and a one-cycle done pulse marks the end of each block.

A per-block mode bit selects a reduced sparse mode. It is meant for blocks whose non-zero coefficients all lie in the top-left 4x4 corner. In sparse mode only four rows are transferred, and only the first four entries of each are used. Both passes then drop every product that involves inputs 4 to 7, so each rotation term becomes a single rounded product. Because of the ping-pong buffer, one block can load while the previous one is still computing or waiting for the consumer.

Back-pressure rules:
- A row moves on either port only in a cycle where valid and ready are both high.
- While the consumer holds out_ready low, out_valid stays high and out_row does not change.
- The input side stalls only when both transpose banks hold blocks that are not yet consumed.

Top module: `idct8_2d`

## Requirements
- R1: While reset is asserted and right after it, in_ready is 1, out_valid is 0 and out_done is 0.
- R2: A full-mode block is carried by eight accepted input rows, in row order 0 to 7. Element k of a row sits at bits 16k+15:16k of in_row and of out_row. The block comes out as row pass then column pass of the eight-point transform, with these constants on a 2^14 scale: c4=16069, c8=15137, c12=13623, c16=11585, c20=9102, c24=6270, c28=3196.
- R3: Every product pair is summed exactly, then rounded as (sum + 8192) >> 14 with arithmetic shift. Every stored result and every butterfly add is kept to 16 bits with two's-complement wraparound. No scaling is applied between the passes.
- R4: In sparse mode a block is exactly four input rows. Entries 4 to 7 of those rows are ignored, and the result equals the full transform of the block with everything outside the top-left 4x4 set to zero.
- R5: A block that is zero outside its top-left 4x4 gives bit-identical output rows in full mode and in sparse mode.
- R6: in_sparse is sampled only with the first row of a block. Its value on later rows has no effect.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_row stays stable in the next cycle.
- R8: out_done is high for exactly one cycle. That cycle immediately follows the acceptance of the eighth row of a block, and out_done is low at all other times.
- R9: When the output side is idle, out_valid rises 9 cycles after the clock edge that accepts the last input row of a block.
- R10: With the output stalled, a second block is accepted with no input stall. Once three blocks have entered, in_ready is low.
- R11: Blocks leave in arrival order, and each block's rows leave in order 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input row valid |
| in_ready | output | 1 | Input row can be accepted |
| in_sparse | input | 1 | Block mode, sampled with the first row: 1 sparse, 0 full |
| in_row | input | 128 | Eight signed 16-bit coefficients, element k at bits 16k+15:16k |
| out_valid | output | 1 | Output row valid |
| out_ready | input | 1 | Consumer accepts the output row |
| out_row | output | 128 | Eight signed 16-bit residuals, element k at bits 16k+15:16k |
| out_done | output | 1 | One-cycle pulse after the eighth output row of a block |

## Verification
The first output row of a block is due 9 cycles after the edge that accepts its last input row. The bench measures this gap at the falling edges that follow that acceptance and compares it with 9. out_done is due in the cycle after the eighth output handshake, and out_valid and out_row are due to hold in the cycle after any stalled cycle. The monitor checks both at the next falling edge after the triggering handshake or stall. Row values have no fixed arrival cycle under random back-pressure, so a scoreboard queue matches them in order as each output handshake occurs.

// File: rtl/idct8_pkg.sv
package idct8_pkg;
  localparam int W     = 16;
  localparam int N     = 8;
  localparam int HALF  = N / 2;
  localparam int IW    = $clog2(N);
  localparam int FB    = 14;
  localparam int PW    = 2 * W + 2;
  localparam int BANKS = 2;
  localparam int BW    = $clog2(BANKS);

  typedef logic signed [W-1:0]  samp_t;
  typedef samp_t [N-1:0]        vec_t;
  typedef logic signed [PW-1:0] prod_t;

  localparam samp_t K4  = 16'sd16069;
  localparam samp_t K8  = 16'sd15137;
  localparam samp_t K12 = 16'sd13623;
  localparam samp_t K16 = 16'sd11585;
  localparam samp_t K20 = 16'sd9102;
  localparam samp_t K24 = 16'sd6270;
  localparam samp_t K28 = 16'sd3196;

  function automatic prod_t mulc(samp_t a, samp_t c);
    return prod_t'(a) * prod_t'(c);
  endfunction

  function automatic samp_t rnd(prod_t p);
    prod_t t;
    t = (p + (prod_t'(1) <<< (FB - 1))) >>> FB;
    return t[W-1:0];
  endfunction
endpackage

// File: rtl/idct8_bfly.sv
module idct8_bfly
  import idct8_pkg::*;
(
  input  logic sparse,
  input  vec_t x,
  output vec_t y
);
  // second-product terms: zero in sparse mode, leaving single rounded products
  prod_t q7a, q7b, q3a, q3b, q4, q6a, q6b;
  assign q7a = sparse ? '0 : mulc(x[7], K4);
  assign q7b = sparse ? '0 : mulc(x[7], K28);
  assign q3a = mulc(x[3], K20);
  assign q3b = mulc(x[3], K12);
  assign q4  = sparse ? '0 : mulc(x[4], K16);
  assign q6a = sparse ? '0 : mulc(x[6], K8);
  assign q6b = sparse ? '0 : mulc(x[6], K24);

  prod_t p5a, p5b;
  assign p5a = sparse ? '0 : mulc(x[5], K12);
  assign p5b = sparse ? '0 : mulc(x[5], K20);

  // odd half, first rotation
  samp_t a4, a5, a6, a7;
  assign a4 = rnd(mulc(x[1], K28) - q7a);
  assign a7 = rnd(mulc(x[1], K4)  + q7b);
  assign a5 = rnd(p5a - q3a);
  assign a6 = rnd(p5b + q3b);

  // even half
  samp_t e0, e1f, e1, e2, e3;
  assign e0  = rnd(mulc(x[0], K16) + q4);
  assign e1f = rnd(mulc(x[0], K16) - q4);
  assign e1  = sparse ? e0 : e1f;
  assign e2  = rnd(mulc(x[2], K24) - q6a);
  assign e3  = rnd(mulc(x[2], K8)  + q6b);

  samp_t b4, b5, b6, b7;
  assign b4 = samp_t'(a4 + a5);
  assign b5 = samp_t'(a4 - a5);
  assign b6 = samp_t'(a7 - a6);
  assign b7 = samp_t'(a7 + a6);

  samp_t f0, f1, f2, f3;
  assign f0 = samp_t'(e0 + e3);
  assign f1 = samp_t'(e1 + e2);
  assign f2 = samp_t'(e1 - e2);
  assign f3 = samp_t'(e0 - e3);

  // odd half, second rotation by c16
  samp_t g5, g6;
  assign g5 = rnd(mulc(b6, K16) - mulc(b5, K16));
  assign g6 = rnd(mulc(b5, K16) + mulc(b6, K16));

  assign y[0] = samp_t'(f0 + b7);
  assign y[1] = samp_t'(f1 + g6);
  assign y[2] = samp_t'(f2 + g5);
  assign y[3] = samp_t'(f3 + b4);
  assign y[4] = samp_t'(f3 - b4);
  assign y[5] = samp_t'(f2 - g5);
  assign y[6] = samp_t'(f1 - g6);
  assign y[7] = samp_t'(f0 - b7);
endmodule

// File: rtl/idct8_tbuf.sv
module idct8_tbuf
  import idct8_pkg::*;
(
  input  logic          clk,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_bank,
  input  logic [IW-1:0] wr_idx,
  input  vec_t          wr_vec,
  input  logic [BW-1:0] rd_bank,
  input  logic [IW-1:0] rd_col,
  input  logic          rd_mask_hi,
  output vec_t          rd_vec
);
  vec_t col_b [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    vec_t rows [N];
    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == BW'(b)) rows[wr_idx] <= wr_vec;
    end
    for (genvar r = 0; r < N; r++) begin : g_row
      assign col_b[b][r] = rows[r][rd_col];
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_mask
    if (r < HALF) begin : g_lo
      assign rd_vec[r] = col_b[rd_bank][r];
    end else begin : g_hi
      assign rd_vec[r] = rd_mask_hi ? '0 : col_b[rd_bank][r];
    end
  end
endmodule

// File: rtl/idct8_obuf.sv
module idct8_obuf
  import idct8_pkg::*;
(
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_col,
  input  vec_t          wr_vec,
  input  logic [IW-1:0] rd_row,
  output vec_t          rd_vec
);
  vec_t rows [N];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int r = 0; r < N; r++) rows[r][wr_col] <= wr_vec[r];
    end
  end

  assign rd_vec = rows[rd_row];
endmodule

// File: rtl/idct8_2d.sv
module idct8_2d
  import idct8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sparse,
  input  logic [N*W-1:0]   in_row,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [N*W-1:0]   out_row,
  output logic             out_done
);
  // ---------------- load side: row pass on arrival ----------------
  logic             ld_bank;
  logic [IW-1:0]    ld_row;
  logic             ld_sparse_q;
  logic [BANKS-1:0] bank_full;
  logic [BANKS-1:0] bank_sparse;

  logic ld_fire, ld_sparse_now, ld_last;
  vec_t in_vec, p1_vec;

  assign in_vec        = vec_t'(in_row);
  assign in_ready      = !bank_full[ld_bank];
  assign ld_fire       = in_valid && in_ready;
  assign ld_sparse_now = (ld_row == '0) ? in_sparse : ld_sparse_q;
  assign ld_last       = ld_sparse_now ? (ld_row == IW'(HALF - 1))
                                       : (ld_row == IW'(N - 1));

  idct8_bfly u_pass1 (
    .sparse (ld_sparse_now),
    .x      (in_vec),
    .y      (p1_vec)
  );

  // ---------------- compute side: column pass ----------------
  logic          cp_active;
  logic          cp_bank;
  logic [IW-1:0] cp_col;
  logic          cp_sparse;
  logic          cp_end;
  vec_t          col_vec, p2_vec;

  logic          ob_full;
  logic [IW-1:0] ob_row;
  logic          out_fire;
  vec_t          ob_vec;

  assign cp_sparse = bank_sparse[cp_bank];
  assign cp_end    = cp_active && (cp_col == IW'(N - 1));

  idct8_tbuf u_tbuf (
    .clk        (clk),
    .wr_en      (ld_fire),
    .wr_bank    (ld_bank),
    .wr_idx     (ld_row),
    .wr_vec     (p1_vec),
    .rd_bank    (cp_bank),
    .rd_col     (cp_col),
    .rd_mask_hi (cp_sparse),
    .rd_vec     (col_vec)
  );

  idct8_bfly u_pass2 (
    .sparse (cp_sparse),
    .x      (col_vec),
    .y      (p2_vec)
  );

  idct8_obuf u_obuf (
    .clk    (clk),
    .wr_en  (cp_active),
    .wr_col (cp_col),
    .wr_vec (p2_vec),
    .rd_row (ob_row),
    .rd_vec (ob_vec)
  );

  assign out_valid = ob_full;
  assign out_row   = ob_vec;
  assign out_fire  = out_valid && out_ready;

  // load control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_bank     <= 1'b0;
      ld_row      <= '0;
      ld_sparse_q <= 1'b0;
    end else if (ld_fire) begin
      ld_sparse_q <= ld_sparse_now;
      if (ld_last) begin
        ld_row  <= '0;
        ld_bank <= ~ld_bank;
      end else begin
        ld_row <= ld_row + 1'b1;
      end
    end
  end

  // bank occupancy: filled by the load side, released by the compute side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_full   <= '0;
      bank_sparse <= '0;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (ld_fire && ld_last && ld_bank == BW'(b)) begin
          bank_full[b]   <= 1'b1;
          bank_sparse[b] <= ld_sparse_now;
        end else if (cp_end && cp_bank == BW'(b)) begin
          bank_full[b] <= 1'b0;
        end
      end
    end
  end

  // compute control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_active <= 1'b0;
      cp_bank   <= 1'b0;
      cp_col    <= '0;
    end else if (!cp_active) begin
      if (bank_full[cp_bank] && !ob_full) begin
        cp_active <= 1'b1;
        cp_col    <= '0;
      end
    end else begin
      cp_col <= cp_col + 1'b1;
      if (cp_end) begin
        cp_active <= 1'b0;
        cp_bank   <= ~cp_bank;
      end
    end
  end

  // output control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_full  <= 1'b0;
      ob_row   <= '0;
      out_done <= 1'b0;
    end else begin
      out_done <= out_fire && (ob_row == IW'(N - 1));
      if (cp_end) begin
        ob_full <= 1'b1;
        ob_row  <= '0;
      end else if (out_fire) begin
        if (ob_row == IW'(N - 1)) ob_full <= 1'b0;
        ob_row <= ob_row + 1'b1;
      end
    end
  end
endmodule

// File: rtl/idct8_2d_chk.sv
module idct8_2d_chk
  import idct8_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [N*W-1:0]   out_row,
  input logic             out_done,
  input logic [BANKS-1:0] bank_full
);
  // R7
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_row));

  // R8
  done_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $past(out_valid && out_ready));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  // R10
  stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (bank_full == '1));
endmodule

bind idct8_2d idct8_2d_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_row   (out_row),
  .out_done  (out_done),
  .bank_full (bank_full)
);

// File: tb/idct8_2d_tb.sv
`timescale 1ns/1ps
module idct8_2d_tb;
  localparam int NE = 8;

  typedef int v8_t [NE];

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid, in_ready, in_sparse;
  logic [127:0]   in_row;
  logic           out_valid, out_ready, out_done;
  logic [127:0]   out_row;

  int checks = 0;
  int fails  = 0;
  int ready_mode = 0;   // 0 always ready, 1 never, 2 random
  int last_stalls;
  int blk [NE][NE];

  logic [127:0] exp_q [$];
  string        tag_q [$];

  always #2.5 clk = ~clk;

  idct8_2d u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sparse (in_sparse),
    .in_row    (in_row),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_row   (out_row),
    .out_done  (out_done)
  );

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference arithmetic (R2, R3) ----------------
  function automatic int w16(longint v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic int r14(longint v);
    return w16((v + 64'sd8192) >>> 14);
  endfunction

  function automatic v8_t idct1(v8_t x);
    v8_t y;
    int o4, o5, o6, o7, e0, e1, e2, e3, m4, m5, m6, m7, s0, s1, s2, s3, h5, h6;
    o4 = r14(longint'(x[1]) * 3196  - longint'(x[7]) * 16069);
    o7 = r14(longint'(x[1]) * 16069 + longint'(x[7]) * 3196);
    o5 = r14(longint'(x[5]) * 13623 - longint'(x[3]) * 9102);
    o6 = r14(longint'(x[5]) * 9102  + longint'(x[3]) * 13623);
    e0 = r14((longint'(x[0]) + longint'(x[4])) * 11585);
    e1 = r14((longint'(x[0]) - longint'(x[4])) * 11585);
    e2 = r14(longint'(x[2]) * 6270  - longint'(x[6]) * 15137);
    e3 = r14(longint'(x[2]) * 15137 + longint'(x[6]) * 6270);
    m4 = w16(o4 + o5); m5 = w16(o4 - o5);
    m6 = w16(o7 - o6); m7 = w16(o7 + o6);
    s0 = w16(e0 + e3); s1 = w16(e1 + e2);
    s2 = w16(e1 - e2); s3 = w16(e0 - e3);
    h5 = r14((longint'(m6) - longint'(m5)) * 11585);
    h6 = r14((longint'(m6) + longint'(m5)) * 11585);
    y[0] = w16(s0 + m7); y[7] = w16(s0 - m7);
    y[1] = w16(s1 + h6); y[6] = w16(s1 - h6);
    y[2] = w16(s2 + h5); y[5] = w16(s2 - h5);
    y[3] = w16(s3 + m4); y[4] = w16(s3 - m4);
    return y;
  endfunction

  function automatic logic [127:0] pack(v8_t v);
    logic [127:0] r;
    for (int k = 0; k < NE; k++) r[16*k +: 16] = v[k][15:0];
    return r;
  endfunction

  task automatic push_expected(bit sparse, string tag);
    v8_t mid [NE];
    v8_t res [NE];
    for (int r = 0; r < NE; r++) begin
      v8_t row;
      for (int c = 0; c < NE; c++)
        row[c] = (sparse && (r >= 4 || c >= 4)) ? 0 : blk[r][c];
      mid[r] = idct1(row);
    end
    for (int c = 0; c < NE; c++) begin
      v8_t col, oc;
      for (int r = 0; r < NE; r++) col[r] = mid[r][c];
      oc = idct1(col);
      for (int r = 0; r < NE; r++) res[r][c] = oc[r];
    end
    for (int r = 0; r < NE; r++) begin
      exp_q.push_back(pack(res[r]));
      tag_q.push_back(tag);
    end
  endtask

  // ---------------- driver (called at a falling edge) ----------------
  task automatic send_block(bit sparse, bit later_mode, string tag);
    int nrows = sparse ? 4 : 8;
    push_expected(sparse, tag);
    last_stalls = 0;
    for (int r = 0; r < nrows; r++) begin
      v8_t v;
      bit rdy;
      for (int c = 0; c < NE; c++) v[c] = blk[r][c];
      in_valid  = 1'b1;
      in_row    = pack(v);
      in_sparse = (r == 0) ? sparse : later_mode;
      forever begin
        rdy = in_ready;
        @(negedge clk);
        if (rdy) break;
        last_stalls++;
      end
    end
    in_valid  = 1'b0;
    in_sparse = 1'b0;
  endtask

  task automatic fill_rand(int amp);
    for (int r = 0; r < NE; r++)
      for (int c = 0; c < NE; c++)
        blk[r][c] = int'($urandom_range(0, 2 * amp)) - amp;
  endtask

  task automatic clear_outside();
    for (int r = 0; r < NE; r++)
      for (int c = 0; c < NE; c++)
        if (r >= 4 || c >= 4) blk[r][c] = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // ---------------- back-pressure generator ----------------
  always @(posedge clk) begin
    #1;
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'b0;
      default: out_ready = $urandom_range(0, 1) != 0;
    endcase
  end

  // ---------------- monitor / scoreboard ----------------
  initial begin
    int row_idx = 0;
    bit pend_done = 0, hold_chk = 0;
    logic [127:0] held;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pend_done) begin
          check(out_done === 1'b1, "R8 done pulse", {127'b0, out_done}, 128'd1);
          pend_done = 0;
        end else if (out_done !== 1'b0) begin
          check(0, "R8 stray done", {127'b0, out_done}, 128'd0);
        end
        if (hold_chk)
          check(out_valid === 1'b1 && out_row === held, "R7 hold under stall", out_row, held);
        hold_chk = out_valid && !out_ready;
        held     = out_row;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(0, "R11 unexpected row", out_row, 128'd0);
          end else begin
            logic [127:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_row === e, t, out_row, e);
          end
          row_idx++;
          if (row_idx == NE) begin
            row_idx   = 0;
            pend_done = 1;
          end
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int n;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sparse = 1'b0;
    in_row    = '0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(in_ready === 1'b1 && out_valid === 1'b0 && out_done === 1'b0, "R1 reset state",
          {125'b0, in_ready, out_valid, out_done}, 128'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0 && out_done === 1'b0, "R1 after reset",
          {125'b0, in_ready, out_valid, out_done}, 128'b100);

    // R9 latency with idle output, DC block
    for (int r = 0; r < NE; r++) for (int c = 0; c < NE; c++) blk[r][c] = 0;
    blk[0][0] = 1024;
    send_block(0, 0, "R2 dc block");
    n = 0;
    while (!out_valid && n < 50) begin @(negedge clk); n++; end
    check(n == 9, "R9 first-row latency", 128'(n), 128'd9);
    drain();

    // R2 random full blocks with random back-pressure
    ready_mode = 2;
    for (int b = 0; b < 3; b++) begin
      fill_rand(1024);
      send_block(0, 0, "R2 full block");
    end
    // R3 extreme values exercising wraparound
    fill_rand(32767);
    send_block(0, 0, "R3 wrap block");
    blk[0] = '{32767, -32768, 32767, -32768, 32767, -32768, 32767, -32768};
    send_block(0, 0, "R3 alternating extremes");
    drain();

    // R4 sparse with junk outside the 4x4 corner
    fill_rand(2000);
    send_block(1, 1, "R4 sparse ignores outer entries");
    // R5 same corner-only block in both modes
    fill_rand(3000);
    clear_outside();
    send_block(0, 0, "R5 corner block full mode");
    send_block(1, 1, "R5 corner block sparse mode");
    // R6 mode bit changes after the first row
    fill_rand(1500);
    send_block(0, 1, "R6 full despite later sparse bit");
    fill_rand(1500);
    send_block(1, 0, "R6 sparse despite later full bit");
    drain();

    // R10 ping-pong with output stalled
    ready_mode = 1;
    repeat (2) @(negedge clk);
    fill_rand(800);
    send_block(0, 0, "R11 order block A");
    fill_rand(800);
    send_block(0, 0, "R11 order block B");
    check(last_stalls == 0, "R10 second block no stall", 128'(last_stalls), 128'd0);
    fill_rand(800);
    send_block(0, 0, "R11 order block C");
    repeat (2) @(negedge clk);
    check(in_ready === 1'b0, "R10 stall after three blocks", {127'b0, in_ready}, 128'd0);
    ready_mode = 0;
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule